// File: doc/BRIEF.md
# Dual Lookup-Table Logic Slice

This block is one logic slice built around two 4-input lookup tables, here called F and G. Each table holds 16 truth-table bits. They are taken from static configuration inputs while reset is held. In logic mode a table simply returns the bit its four inputs address. A fifth select input steers between the two table outputs, so the pair can realise any function of five variables.

Each table can be switched, per table and before reset is released, into a memory role. As a 16x1 RAM it takes a synchronous write and gives an asynchronous read. As a 16-stage shift register its output tap is chosen by the same four inputs.

A two-bit carry chain lets the pair act as two adder bits, with the tables programmed as propagate functions. Two storage elements capture the per-table results. Each can run as an edge-triggered flip-flop or as a level-sensitive latch that is transparent while the clock is high.

Top module: `lutpair_slice`

## Requirements
- R1: While `rst` is high at a rising clock edge, the F and G contents are loaded from `fInit` and `gInit`. While `rst` is high, `xReg` and `yReg` are 0.
- R2: In logic mode (mode code 2'b00), `fOut` equals bit `fAddr` of the loaded F contents, and `gOut` equals bit `gAddr` of the loaded G contents. `wrEn`, `fDin` and `gDin` leave the contents unchanged.
- R3: `wideOut` equals `gOut` when `sel5` is 1 and `fOut` when `sel5` is 0. With `fAddr` equal to `gAddr`, this gives a 5-input function whose top variable is `sel5`.
- R4: In RAM mode (2'b01), a rising edge with `wrEn` high writes the data input into the bit at the table's address. Reads follow the address with no clock. With `wrEn` low, nothing is written.
- R5: In shift mode (2'b10), a rising edge with `wrEn` high moves every stage i to stage i+1 and puts the data input into stage 0. The output shows the stage named by the address. With `wrEn` low, the stages hold.
- R6: The carry chain treats address bit 0 as operand a and bit 1 as operand b. F is bit 0, fed by `carryIn`, and G is bit 1. Each bit's carry is (a AND b) OR (cin AND (a XOR b)), and `carryOut` is the carry out of G.
- R7: With `arithEn` high, `xComb` = `fOut` XOR `carryIn` and `yComb` = `gOut` XOR the carry between the bits. With `arithEn` low, `xComb` = `fOut` and `yComb` = `gOut`.
- R8: With `latchMode` low, `xReg` and `yReg` take `xComb` and `yComb` at each rising edge.
- R9: With `latchMode` high, `xReg` and `yReg` follow `xComb` and `yComb` while `clk` is high, and hold while `clk` is low.
- R10: The two tables take their modes independently. Mode code 2'b11 behaves as logic mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the latch transparency level |
| rst | input | 1 | Synchronous reset; loads the table contents |
| fInit | input | 16 | F truth table, captured in reset |
| gInit | input | 16 | G truth table, captured in reset |
| fMode | input | 2 | F mode: 00 logic, 01 RAM, 10 shift, 11 logic |
| gMode | input | 2 | G mode, same coding |
| arithEn | input | 1 | Storage and comb outputs take sums instead of table outputs |
| latchMode | input | 1 | Storage acts as latch (1) or flip-flop (0) |
| fAddr | input | 4 | F table inputs / address |
| gAddr | input | 4 | G table inputs / address |
| sel5 | input | 1 | Fifth input of the wide multiplexer |
| wrEn | input | 1 | Write or shift enable for tables in a memory mode |
| fDin | input | 1 | Data into F in RAM or shift mode |
| gDin | input | 1 | Data into G in RAM or shift mode |
| carryIn | input | 1 | Carry into bit 0 |
| fOut | output | 1 | F table output |
| gOut | output | 1 | G table output |
| wideOut | output | 1 | Wide multiplexer output |
| carryOut | output | 1 | Carry out of bit 1 |
| xComb | output | 1 | Unregistered bit-0 result |
| yComb | output | 1 | Unregistered bit-1 result |
| xReg | output | 1 | Stored bit-0 result |
| yReg | output | 1 | Stored bit-1 result |

## Verification
The only hidden state is the two 16-bit tables. A wrong bit in either shows up at `fOut` or `gOut` as soon as the address reaches it, with no clock needed, so every address is swept after each reset, write and shift sequence. A mis-ordered shift or a write to the wrong address shows up one edge later at the stage or address that was checked. Storage mistakes show within half a clock period, since the latch is checked in both clock phases and the flip-flop right after each edge.

// File: rtl/lutpair_pkg.sv
package lutpair_pkg;

  typedef enum logic [1:0] {
    LM_LOGIC = 2'b00,
    LM_RAM   = 2'b01,
    LM_SHIFT = 2'b10,
    LM_SPARE = 2'b11
  } lutMode_e;

  typedef struct packed {
    logic load;
    logic fWr;
    logic fShift;
    logic gWr;
    logic gShift;
  } sliceStrobe_t;

endpackage

// File: rtl/lutpair_ctrl.sv
module lutpair_ctrl
  import lutpair_pkg::*;
(
  input  logic         rst,
  input  logic [1:0]   fMode,
  input  logic [1:0]   gMode,
  input  logic         wrEn,
  output sliceStrobe_t strb
);

  lutMode_e fModeE;
  lutMode_e gModeE;

  assign fModeE = lutMode_e'(fMode);
  assign gModeE = lutMode_e'(gMode);

  // Reset overrides every write; spare code falls through as logic (R10)
  always_comb begin
    strb        = '0;
    strb.load   = rst;
    strb.fWr    = !rst && wrEn && (fModeE == LM_RAM);
    strb.fShift = !rst && wrEn && (fModeE == LM_SHIFT);
    strb.gWr    = !rst && wrEn && (gModeE == LM_RAM);
    strb.gShift = !rst && wrEn && (gModeE == LM_SHIFT);
  end

endmodule

// File: rtl/lutpair_cell.sv
module lutpair_cell #(
  parameter int IN_W = 4
) (
  input  logic                  clk,
  input  logic                  load,
  input  logic [(1<<IN_W)-1:0]  initBits,
  input  logic                  wr,
  input  logic                  shift,
  input  logic [IN_W-1:0]       addr,
  input  logic                  din,
  output logic                  dout
);

  localparam int DEPTH = 1 << IN_W;

  logic [DEPTH-1:0] cells;

  always_ff @(posedge clk) begin
    if (load)       cells <= initBits;
    else if (wr)    cells[addr] <= din;
    else if (shift) cells <= {cells[DEPTH-2:0], din};
  end

  assign dout = cells[addr];

  a_r4_ram_write: assert property (@(posedge clk) disable iff (load)
    wr |=> cells[$past(addr)] == $past(din));

  a_r5_shift_step: assert property (@(posedge clk) disable iff (load)
    shift |=> cells == {$past(cells[DEPTH-2:0]), $past(din)});

  a_r2_hold_contents: assert property (@(posedge clk) disable iff (load)
    (!wr && !shift) |=> $stable(cells));

endmodule

// File: rtl/lutpair_dp.sv
module lutpair_dp
  import lutpair_pkg::*;
#(
  parameter int IN_W = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  sliceStrobe_t          strb,
  input  logic [(1<<IN_W)-1:0]  fInit,
  input  logic [(1<<IN_W)-1:0]  gInit,
  input  logic [IN_W-1:0]       fAddr,
  input  logic [IN_W-1:0]       gAddr,
  input  logic                  fDin,
  input  logic                  gDin,
  input  logic                  sel5,
  input  logic                  carryIn,
  input  logic                  arithEn,
  input  logic                  latchMode,
  output logic                  fOut,
  output logic                  gOut,
  output logic                  wideOut,
  output logic                  carryOut,
  output logic                  xComb,
  output logic                  yComb,
  output logic                  xReg,
  output logic                  yReg
);

  localparam int DEPTH  = 1 << IN_W;
  localparam int N_LUTS = 2;

  logic [N_LUTS-1:0][DEPTH-1:0] initArr;
  logic [N_LUTS-1:0][IN_W-1:0]  addrArr;
  logic [N_LUTS-1:0]            dinArr;
  logic [N_LUTS-1:0]            wrArr;
  logic [N_LUTS-1:0]            shArr;
  logic [N_LUTS-1:0]            lutOut;
  logic [N_LUTS:0]              cChain;
  logic [N_LUTS-1:0]            stageD;
  logic [N_LUTS-1:0]            regQ;

  assign initArr = {gInit, fInit};
  assign addrArr = {gAddr, fAddr};
  assign dinArr  = {gDin, fDin};
  assign wrArr   = {strb.gWr, strb.fWr};
  assign shArr   = {strb.gShift, strb.fShift};
  assign cChain[0] = carryIn;

  for (genvar i = 0; i < N_LUTS; i++) begin : g_bit
    logic opA;
    logic opB;
    logic sumBit;
    logic ffBit;
    logic latBit;

    lutpair_cell #(.IN_W(IN_W)) u_cell (
      .clk      (clk),
      .load     (strb.load),
      .initBits (initArr[i]),
      .wr       (wrArr[i]),
      .shift    (shArr[i]),
      .addr     (addrArr[i]),
      .din      (dinArr[i]),
      .dout     (lutOut[i])
    );

    // R6 carry: a = address bit 0, b = address bit 1
    assign opA         = addrArr[i][0];
    assign opB         = addrArr[i][1];
    assign cChain[i+1] = (opA & opB) | (cChain[i] & (opA ^ opB));
    assign sumBit      = lutOut[i] ^ cChain[i];
    assign stageD[i]   = arithEn ? sumBit : lutOut[i];

    always_ff @(posedge clk) begin
      if (rst) ffBit <= 1'b0;
      else     ffBit <= stageD[i];
    end

    // R9 level-sensitive element, open while clk is high
    always_latch begin
      if (rst)      latBit <= 1'b0;
      else if (clk) latBit <= stageD[i];
    end

    assign regQ[i] = latchMode ? latBit : ffBit;

    a_r8_ff_capture: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ffBit == $past(stageD[i]));
  end

  assign fOut     = lutOut[0];
  assign gOut     = lutOut[1];
  assign wideOut  = sel5 ? lutOut[1] : lutOut[0];
  assign carryOut = cChain[N_LUTS];
  assign xComb    = stageD[0];
  assign yComb    = stageD[1];
  assign xReg     = regQ[0];
  assign yReg     = regQ[1];

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!latchMode || !xReg) && (!latchMode || !yReg) || !rst);

endmodule

// File: rtl/lutpair_slice.sv
module lutpair_slice
  import lutpair_pkg::*;
#(
  parameter int IN_W = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [(1<<IN_W)-1:0]  fInit,
  input  logic [(1<<IN_W)-1:0]  gInit,
  input  logic [1:0]            fMode,
  input  logic [1:0]            gMode,
  input  logic                  arithEn,
  input  logic                  latchMode,
  input  logic [IN_W-1:0]       fAddr,
  input  logic [IN_W-1:0]       gAddr,
  input  logic                  sel5,
  input  logic                  wrEn,
  input  logic                  fDin,
  input  logic                  gDin,
  input  logic                  carryIn,
  output logic                  fOut,
  output logic                  gOut,
  output logic                  wideOut,
  output logic                  carryOut,
  output logic                  xComb,
  output logic                  yComb,
  output logic                  xReg,
  output logic                  yReg
);

  sliceStrobe_t strb;

  lutpair_ctrl u_ctrl (
    .rst   (rst),
    .fMode (fMode),
    .gMode (gMode),
    .wrEn  (wrEn),
    .strb  (strb)
  );

  lutpair_dp #(.IN_W(IN_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .fInit     (fInit),
    .gInit     (gInit),
    .fAddr     (fAddr),
    .gAddr     (gAddr),
    .fDin      (fDin),
    .gDin      (gDin),
    .sel5      (sel5),
    .carryIn   (carryIn),
    .arithEn   (arithEn),
    .latchMode (latchMode),
    .fOut      (fOut),
    .gOut      (gOut),
    .wideOut   (wideOut),
    .carryOut  (carryOut),
    .xComb     (xComb),
    .yComb     (yComb),
    .xReg      (xReg),
    .yReg      (yReg)
  );

endmodule

// File: tb/tb_lutpair_slice.sv
`timescale 1ns/100ps
module tb_lutpair_slice;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] fInit = 16'hA5C3;
  logic [15:0] gInit = 16'h3C96;
  logic [1:0]  fMode = 2'b00;
  logic [1:0]  gMode = 2'b00;
  logic arithEn = 1'b0;
  logic latchMode = 1'b0;
  logic [3:0] fAddr = '0;
  logic [3:0] gAddr = '0;
  logic sel5 = 1'b0;
  logic wrEn = 1'b0;
  logic fDin = 1'b0;
  logic gDin = 1'b0;
  logic carryIn = 1'b0;
  logic fOut, gOut, wideOut, carryOut, xComb, yComb, xReg, yReg;

  int total = 0;
  int fails = 0;
  bit done = 0;
  logic [15:0] fm, gm;

  always #2.5 clk = ~clk;

  lutpair_slice dut (
    .clk(clk), .rst(rst), .fInit(fInit), .gInit(gInit), .fMode(fMode), .gMode(gMode),
    .arithEn(arithEn), .latchMode(latchMode), .fAddr(fAddr), .gAddr(gAddr), .sel5(sel5),
    .wrEn(wrEn), .fDin(fDin), .gDin(gDin), .carryIn(carryIn), .fOut(fOut), .gOut(gOut),
    .wideOut(wideOut), .carryOut(carryOut), .xComb(xComb), .yComb(yComb),
    .xReg(xReg), .yReg(yReg)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    wrEn = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // operand pattern v: a0=v[0] b0=v[1] a1=v[2] b1=v[3] cin=v[4]
  task automatic setAdd(input int v);
    fAddr = {2'b00, v[1], v[0]};
    gAddr = {2'b00, v[3], v[2]};
    carryIn = v[4];
  endtask

  function automatic logic [2:0] addSum(input int v);
    return 3'({v[2], v[0]}) + 3'({v[3], v[1]}) + 3'(v[4]);
  endfunction

  initial begin
    // ---- reset state and logic mode
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check("R1 xReg in reset", {7'b0, xReg}, 8'd0);
    check("R1 yReg in reset", {7'b0, yReg}, 8'd0);
    @(negedge clk);
    rst = 1'b0;
    for (int a = 0; a < 16; a++) begin
      fAddr = 4'(a); gAddr = 4'(15 - a);
      #1;
      check("R1 R2 fOut logic", {7'b0, fOut}, {7'b0, fInit[a]});
      check("R2 gOut logic", {7'b0, gOut}, {7'b0, gInit[15 - a]});
      check("R7 xComb passthrough", {7'b0, xComb}, {7'b0, fInit[a]});
    end
    // writes attempted in logic mode must not alter contents
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      wrEn = 1'b1; fAddr = 4'(k); gAddr = 4'(k);
      fDin = ~fInit[k]; gDin = ~gInit[k];
    end
    @(negedge clk);
    wrEn = 1'b0;
    for (int a = 0; a < 16; a++) begin
      fAddr = 4'(a); gAddr = 4'(a);
      #1;
      check("R2 F unchanged", {7'b0, fOut}, {7'b0, fInit[a]});
      check("R2 G unchanged", {7'b0, gOut}, {7'b0, gInit[a]});
    end
    // ---- wide multiplexer, all 32 input combinations
    for (int v = 0; v < 32; v++) begin
      fAddr = 4'(v); gAddr = 4'(v); sel5 = v[4];
      #1;
      check("R3 wideOut", {7'b0, wideOut}, {7'b0, v[4] ? gInit[v % 16] : fInit[v % 16]});
    end

    // ---- adder: both tables hold a XOR b
    fInit = 16'h6666; gInit = 16'h6666; arithEn = 1'b1;
    doReset();
    for (int v = 0; v < 32; v++) begin
      logic [2:0] s;
      s = addSum(v);
      setAdd(v);
      #1;
      check("R7 xComb sum", {7'b0, xComb}, {7'b0, s[0]});
      check("R7 yComb sum", {7'b0, yComb}, {7'b0, s[1]});
      check("R6 carryOut", {7'b0, carryOut}, {7'b0, s[2]});
      @(posedge clk); #1;
      check("R8 xReg ff", {7'b0, xReg}, {7'b0, s[0]});
      check("R8 yReg ff", {7'b0, yReg}, {7'b0, s[1]});
      @(negedge clk);
    end

    // ---- latch behaviour
    latchMode = 1'b1;
    setAdd(0);
    @(posedge clk); #1;
    @(negedge clk);
    for (int v = 1; v < 32; v += 3) begin
      logic [2:0] s;
      logic [2:0] sp;
      logic [2:0] s2;
      sp = addSum(v - 1);
      s  = addSum(v);
      s2 = addSum((v + 7) % 32);
      setAdd(v);
      #1;
      check("R9 hold while low", {6'b0, yReg, xReg}, {6'b0, sp[1], sp[0]});
      @(posedge clk); #1;
      check("R9 open while high", {6'b0, yReg, xReg}, {6'b0, s[1], s[0]});
      setAdd((v + 7) % 32);
      #0.5;
      check("R9 follows while high", {6'b0, yReg, xReg}, {6'b0, s2[1], s2[0]});
      @(negedge clk);
      setAdd(v);
      #1;
      check("R9 holds after fall", {6'b0, yReg, xReg}, {6'b0, s2[1], s2[0]});
      setAdd(v + 2 < 32 ? v + 2 : v);
      @(negedge clk);
      setAdd(v);
    end
    latchMode = 1'b0; arithEn = 1'b0;

    // ---- RAM mode on both tables
    fInit = 16'h0F0F; gInit = 16'h9999; fMode = 2'b01; gMode = 2'b01;
    doReset();
    fm = fInit; gm = gInit;
    for (int a = 0; a < 16; a++) begin
      fAddr = 4'(a); gAddr = 4'(15 - a);
      fDin = a[0] ^ a[2]; gDin = ~a[1];
      wrEn = 1'b1;
      @(posedge clk); #1;
      fm[a] = a[0] ^ a[2]; gm[15 - a] = ~a[1];
      check("R4 read after write F", {7'b0, fOut}, {7'b0, fm[a]});
      check("R4 read after write G", {7'b0, gOut}, {7'b0, gm[15 - a]});
      @(negedge clk);
    end
    wrEn = 1'b0;
    fAddr = 4'd5; gAddr = 4'd9; fDin = ~fm[5]; gDin = ~gm[9];
    @(posedge clk); #1;
    check("R4 no write when disabled", {6'b0, gOut, fOut}, {6'b0, gm[9], fm[5]});
    @(negedge clk);
    for (int a = 0; a < 16; a++) begin
      fAddr = 4'(a); gAddr = 4'(a);
      #1;
      check("R4 F contents", {7'b0, fOut}, {7'b0, fm[a]});
      check("R4 G contents", {7'b0, gOut}, {7'b0, gm[a]});
    end

    // ---- shift on F, spare code on G
    fInit = 16'h1234; gInit = 16'hC35A; fMode = 2'b10; gMode = 2'b11;
    doReset();
    fm = fInit;
    for (int k = 0; k < 40; k++) begin
      logic en;
      logic d;
      en = (k % 5) != 3;
      d = k[0] ^ k[2];
      wrEn = en; fDin = d; gDin = ~d;
      fAddr = 4'(k % 16); gAddr = 4'((k * 3) % 16);
      @(posedge clk); #1;
      if (en) fm = {fm[14:0], d};
      check("R5 shift tap", {7'b0, fOut}, {7'b0, fm[k % 16]});
      check("R10 spare code is logic", {7'b0, gOut}, {7'b0, gInit[(k * 3) % 16]});
      @(negedge clk);
    end
    wrEn = 1'b0;
    for (int a = 0; a < 16; a++) begin
      fAddr = 4'(a);
      #1;
      check("R5 final stages", {7'b0, fOut}, {7'b0, fm[a]});
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule